// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Unit

This unit turns pin transitions into bank interrupts. Each pin is fed to the unit as a level that is already synchronised to the clock. Each pin also has a 2-bit trigger code that selects rising edges, falling edges, both edges or no detection. A selected transition sets that pin's pending bit in its bank's status register. A bank's interrupt line is high while any pending bit of that bank is not masked.

Software uses a small register window. For each bank there is a status register that is write-one-to-clear, plus a pair of write-one registers: one sets mask bits and the other clears them. Pending bits keep latching while a pin is masked, so unmasking a pin with an event already pending raises the line at once. The usual start-up sequence writes all ones to mask-set and then all ones to status, which leaves a bank silent and clean. Level-sensitive triggering, register locking and debouncing are outside this unit. `NUM_BANKS` may be at most 8, so the bank windows do not overlap.

Top module: `gpio_eirq_top`

## Requirements
- R1: After reset, every status bit is 0, every mask bit is 1 and every bank interrupt is low.
- R2: Pin p's trigger code is `pin_trig[2p+1:2p]`. Code bit 0 enables rising-edge detection. With code 1, a 0→1 change on the pin sets its status bit after the next clock edge, and a 1→0 change does not.
- R3: With code 2 (bit 1 set), a 1→0 change sets the status bit and a 0→1 change does not.
- R4: With code 3, both directions of change set the status bit.
- R5: With code 0, no change on the pin sets its status bit.
- R6: Writing to address 0x080+4·b clears each status bit of bank b whose data bit is 1. Status bits whose data bit is 0 are unchanged, and so are the other banks. A read at that address returns the status.
- R7: Writing to address 0x0A0+4·b sets the mask bits of bank b where the data is 1. Writing to 0x0C0+4·b clears them where the data is 1. A read at 0x0A0+4·b returns the mask.
- R8: `bank_irq[b]` is high exactly when some bit of bank b's status is 1 and the same mask bit is 0.
- R9: Status bits latch while masked. Clearing the mask of a pending bit raises `bank_irq` in the cycle that the write takes effect.
- R10: If a detected edge and a clearing write to the same status bit fall on the same clock edge, the bit ends up set.
- R11: Writes to any other address have no effect, including misaligned addresses and addresses of banks that do not exist. A read of any unmapped address returns 0.
- R12: The first clock edge after reset is released only records the pin levels. A pin that was already high during reset does not count as a rising edge.
- R13: Writing all ones to mask-set and then all ones to status leaves a bank with no pending bit and its interrupt low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_BANKS*PINS | Synchronised pin levels; bank b pin p at index b*PINS+p |
| pin_trig | input | 2*NUM_BANKS*PINS | Per-pin trigger codes, 2 bits per pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte address |
| wr_data | input | PINS | Register write data |
| rd_addr | input | 12 | Register read byte address |
| rd_data | output | PINS | Read data, combinational from `rd_addr` |
| bank_irq | output | NUM_BANKS | One interrupt line per bank |

## Verification
A pin change made between clock edges is sampled on the next rising edge. It appears in status and on `bank_irq` just after that same edge, one cycle after the stimulus. A register write takes effect on the edge where it is held and shows up in the same way. A read needs no cycle, because `rd_data` follows `rd_addr` combinationally. The bench drives all inputs in the low clock phase and updates its model at the rising edge. It then compares status, mask and interrupt lines at the following falling edge, stepping `rd_addr` through every bank window there.

// File: rtl/gpio_eirq_pkg.sv
package gpio_eirq_pkg;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] STAT_BASE = 12'h080;
    localparam logic [ADDR_W-1:0] MSET_BASE = 12'h0A0;
    localparam logic [ADDR_W-1:0] MCLR_BASE = 12'h0C0;

    // trigger code: bit 0 = rising, bit 1 = falling
    typedef enum logic [1:0] {
        TRIG_OFF  = 2'd0,
        TRIG_RISE = 2'd1,
        TRIG_FALL = 2'd2,
        TRIG_BOTH = 2'd3
    } trig_e;

    function automatic logic [ADDR_W-1:0] bank_addr(input logic [ADDR_W-1:0] base, input int b);
        return base + ADDR_W'(4 * b);
    endfunction
endpackage

// File: rtl/gpio_eirq_edge.sv
module gpio_eirq_edge
    import gpio_eirq_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PINS-1:0]   level_i,
    input  logic [2*PINS-1:0] trig_i,
    output logic [PINS-1:0]   event_o
);
    typedef struct packed {
        logic            primed;
        logic [PINS-1:0] prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d.primed = 1'b1;
        st_d.prev   = level_i;
        event_o     = '0;
        for (int p = 0; p < PINS; p++) begin
            trig_e code;
            logic  went_up, went_down;
            code      = trig_e'(trig_i[2*p +: 2]);
            went_up   = level_i[p] & ~st_q.prev[p];
            went_down = ~level_i[p] & st_q.prev[p];
            event_o[p] = st_q.primed &
                         ((went_up   & (code == TRIG_RISE || code == TRIG_BOTH)) |
                          (went_down & (code == TRIG_FALL || code == TRIG_BOTH)));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/gpio_eirq_bank.sv
module gpio_eirq_bank #(
    parameter int PINS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] event_i,
    input  logic [PINS-1:0] clr_i,
    input  logic [PINS-1:0] mset_i,
    input  logic [PINS-1:0] mclr_i,
    output logic [PINS-1:0] status_o,
    output logic [PINS-1:0] mask_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [PINS-1:0] status;
        logic [PINS-1:0] mask;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        // a new event wins over a clear on the same edge
        st_d.status = (st_q.status & ~clr_i) | event_i;
        st_d.mask   = (st_q.mask | mset_i) & ~mclr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);
endmodule

// File: rtl/gpio_eirq_decode.sv
module gpio_eirq_decode
    import gpio_eirq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int PINS      = 32,
    localparam int NPIN     = NUM_BANKS * PINS
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PINS-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPIN-1:0]   status_i,
    input  logic [NPIN-1:0]   mask_i,
    output logic [NPIN-1:0]   clr_o,
    output logic [NPIN-1:0]   mset_o,
    output logic [NPIN-1:0]   mclr_o,
    output logic [PINS-1:0]   rd_data
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_wr
        localparam logic [ADDR_W-1:0] SA = bank_addr(STAT_BASE, b);
        localparam logic [ADDR_W-1:0] MA = bank_addr(MSET_BASE, b);
        localparam logic [ADDR_W-1:0] CA = bank_addr(MCLR_BASE, b);
        assign clr_o [b*PINS +: PINS] = (wr_en && wr_addr == SA) ? wr_data : '0;
        assign mset_o[b*PINS +: PINS] = (wr_en && wr_addr == MA) ? wr_data : '0;
        assign mclr_o[b*PINS +: PINS] = (wr_en && wr_addr == CA) ? wr_data : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rd_addr == bank_addr(STAT_BASE, b)) rd_data = status_i[b*PINS +: PINS];
            if (rd_addr == bank_addr(MSET_BASE, b)) rd_data = mask_i[b*PINS +: PINS];
        end
    end
endmodule

// File: rtl/gpio_eirq_top.sv
module gpio_eirq_top
    import gpio_eirq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int PINS      = 32,
    localparam int NPIN     = NUM_BANKS * PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPIN-1:0]   pin_level,
    input  logic [2*NPIN-1:0] pin_trig,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [PINS-1:0]   wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [PINS-1:0]   rd_data,
    output logic [NUM_BANKS-1:0] bank_irq
);
    logic [NPIN-1:0] evt_all, status_all, mask_all;
    logic [NPIN-1:0] clr_all, mset_all, mclr_all;

    gpio_eirq_decode #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) i_decode (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .status_i (status_all),
        .mask_i   (mask_all),
        .clr_o    (clr_all),
        .mset_o   (mset_all),
        .mclr_o   (mclr_all),
        .rd_data  (rd_data)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_eirq_edge #(.PINS(PINS)) i_edge (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (pin_level[b*PINS +: PINS]),
            .trig_i  (pin_trig[2*b*PINS +: 2*PINS]),
            .event_o (evt_all[b*PINS +: PINS])
        );

        gpio_eirq_bank #(.PINS(PINS)) i_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .event_i  (evt_all[b*PINS +: PINS]),
            .clr_i    (clr_all[b*PINS +: PINS]),
            .mset_i   (mset_all[b*PINS +: PINS]),
            .mclr_i   (mclr_all[b*PINS +: PINS]),
            .status_o (status_all[b*PINS +: PINS]),
            .mask_o   (mask_all[b*PINS +: PINS]),
            .irq_o    (bank_irq[b])
        );
    end
endmodule

// File: rtl/gpio_eirq_chk.sv
module gpio_eirq_chk
    import gpio_eirq_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int PINS      = 32,
    localparam int NPIN     = NUM_BANKS * PINS
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NPIN-1:0]      evt,
    input logic [NPIN-1:0]      status,
    input logic [NPIN-1:0]      mask,
    input logic [2*NPIN-1:0]    pin_trig,
    input logic                 wr_en,
    input logic [ADDR_W-1:0]    wr_addr,
    input logic [PINS-1:0]      wr_data,
    input logic [NUM_BANKS-1:0] bank_irq
);
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_b
        localparam logic [ADDR_W-1:0] SA = bank_addr(STAT_BASE, b);
        localparam logic [ADDR_W-1:0] MA = bank_addr(MSET_BASE, b);

        // R1 / R8: a fully masked bank never interrupts
        p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (&mask[b*PINS +: PINS]) |-> !bank_irq[b]);

        // R9: a pending unmasked bit always drives the line
        p_pending_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (|(status[b*PINS +: PINS] & ~mask[b*PINS +: PINS])) |-> bank_irq[b]);

        for (genvar p = 0; p < PINS; p++) begin : g_p
            localparam int I = b * PINS + p;

            // R10: a detected edge is always recorded
            p_edge_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
                evt[I] |=> status[I]);

            // R5: code 0 never produces an event
            p_code0_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_trig[2*I +: 2] == 2'd0) |-> !evt[I]);

            // R6: a pending bit survives anything but a clearing write
            p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (status[I] && !(wr_en && wr_addr == SA && wr_data[p])) |=> status[I]);

            // R7: mask-set write takes effect on the next edge
            p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && wr_addr == MA && wr_data[p]) |=> mask[I]);
        end
    end
endmodule

bind gpio_eirq_top gpio_eirq_chk #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_all),
    .status   (status_all),
    .mask     (mask_all),
    .pin_trig (pin_trig),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .bank_irq (bank_irq)
);

// File: tb/test_gpio_eirq_top.sv
module test_gpio_eirq_top;
    import gpio_eirq_pkg::*;

    localparam int NB   = 2;
    localparam int W    = 32;
    localparam int NPIN = NB * W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPIN-1:0]   lvl = '0;
    logic [2*NPIN-1:0] trig = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [W-1:0]      wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [W-1:0]      rd_data;
    logic [NB-1:0]     irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [W-1:0]    m_stat [NB];
    logic [W-1:0]    m_mask [NB];
    logic [NPIN-1:0] m_prev;
    bit              m_primed;

    always #10 clk = ~clk;

    gpio_eirq_top #(.NUM_BANKS(NB), .PINS(W)) i_gpio_eirq_top (
        .clk(clk), .rst_n(rst_n), .pin_level(lvl), .pin_trig(trig),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bank_irq(irq)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_stat[b] = '0;
            m_mask[b] = '1;
        end
        m_prev   = '0;
        m_primed = 1'b0;
    endtask

    // one clock edge of the expected behaviour, from the held inputs
    task automatic model_step();
        for (int b = 0; b < NB; b++) begin
            logic [W-1:0] ev, clr, ms, mc;
            for (int p = 0; p < W; p++) begin
                int i;
                i = b * W + p;
                ev[p] = m_primed &&
                        ((lvl[i] && !m_prev[i] && trig[2*i]) ||
                         (!lvl[i] && m_prev[i] && trig[2*i+1]));
            end
            clr = (wr_en && wr_addr == bank_addr(STAT_BASE, b)) ? wr_data : '0;
            ms  = (wr_en && wr_addr == bank_addr(MSET_BASE, b)) ? wr_data : '0;
            mc  = (wr_en && wr_addr == bank_addr(MCLR_BASE, b)) ? wr_data : '0;
            m_stat[b] = (m_stat[b] & ~clr) | ev;
            m_mask[b] = (m_mask[b] | ms) & ~mc;
        end
        m_prev   = lvl;
        m_primed = 1'b1;
    endtask

    task automatic check_all(input string tag);
        for (int b = 0; b < NB; b++) begin
            rd_addr = bank_addr(STAT_BASE, b);
            #1;
            check($sformatf("%s status bank%0d", tag, b), rd_data, m_stat[b]);
            rd_addr = bank_addr(MSET_BASE, b);
            #1;
            check($sformatf("%s mask bank%0d", tag, b), rd_data, m_mask[b]);
            check($sformatf("%s irq bank%0d (R8)", tag, b), W'(irq[b]),
                  W'(|(m_stat[b] & ~m_mask[b])));
        end
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all(tag);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
    endtask

    task automatic set_trig(input int i, input trig_e c);
        trig[2*i +: 2] = c;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        // pin 0 high and rising-enabled during reset
        lvl[0] = 1'b1;
        set_trig(0, TRIG_RISE);
        repeat (2) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        cycle("R12");
        cycle("R12");

        // unmask bank 0
        wr(bank_addr(MCLR_BASE, 0), '1);
        cycle("R7");

        // rising only
        set_trig(1, TRIG_RISE);
        cycle("R2");
        lvl[1] = 1'b1;
        cycle("R2");
        wr(bank_addr(STAT_BASE, 0), 32'h0000_0002);
        cycle("R6");
        lvl[1] = 1'b0;
        cycle("R2");

        // falling only
        set_trig(2, TRIG_FALL);
        lvl[2] = 1'b1;
        cycle("R3");
        lvl[2] = 1'b0;
        cycle("R3");
        wr(bank_addr(STAT_BASE, 0), 32'h0000_0004);
        cycle("R6");

        // both edges
        set_trig(3, TRIG_BOTH);
        lvl[3] = 1'b1;
        cycle("R4");
        wr(bank_addr(STAT_BASE, 0), 32'h0000_0008);
        cycle("R6");
        lvl[3] = 1'b0;
        cycle("R4");

        // code 0
        set_trig(4, TRIG_OFF);
        lvl[4] = 1'b1;
        cycle("R5");
        lvl[4] = 1'b0;
        cycle("R5");

        // partial clear leaves the others and bank 1 alone
        wr(bank_addr(STAT_BASE, 0), 32'h0000_0001);
        cycle("R6");

        // latch while masked, then unmask
        set_trig(W, TRIG_RISE);
        lvl[W] = 1'b1;
        cycle("R9");
        wr(bank_addr(MCLR_BASE, 1), 32'h0000_0001);
        cycle("R9");
        wr(bank_addr(MSET_BASE, 1), 32'h0000_0001);
        cycle("R7");

        // edge and clear on the same edge
        set_trig(5, TRIG_RISE);
        lvl[5] = 1'b1;
        cycle("R10");
        lvl[5] = 1'b0;
        cycle("R10");
        lvl[5] = 1'b1;
        wr(bank_addr(STAT_BASE, 0), 32'h0000_0020);
        cycle("R10");

        // unmapped addresses
        wr(12'h088, '1);
        cycle("R11");
        wr(12'h0C8, '1);
        cycle("R11");
        wr(12'h081, '1);
        cycle("R11");
        wr(12'h0E0, '1);
        cycle("R11");
        rd_addr = 12'h100;
        #1;
        check("R11 unmapped read", rd_data, '0);
        rd_addr = bank_addr(MCLR_BASE, 0);
        #1;
        check("R11 mask-clear read", rd_data, '0);

        // random phase
        for (int n = 0; n < 600; n++) begin
            if (n % 60 == 0) begin
                for (int k = 0; k < 2 * NPIN / 32; k++) trig[32*k +: 32] = $urandom;
            end
            for (int k = 0; k < NPIN / 32; k++) lvl[32*k +: 32] = $urandom;
            if ($urandom_range(9) < 4) begin
                int sel;
                logic [ADDR_W-1:0] a;
                sel = $urandom_range(3);
                a = (sel == 0) ? STAT_BASE : (sel == 1) ? MSET_BASE :
                    (sel == 2) ? MCLR_BASE : 12'h0E4;
                wr(a + ADDR_W'(4 * $urandom_range(NB - 1)), $urandom);
            end
            cycle("R4 random");
        end

        // start-up sequence leaves everything quiet
        for (int b = 0; b < NB; b++) begin
            wr(bank_addr(MSET_BASE, b), '1);
            cycle("R13");
        end
        trig = '0;
        for (int b = 0; b < NB; b++) begin
            wr(bank_addr(STAT_BASE, b), '1);
            cycle("R13");
        end
        check("R13 irq lines", W'(irq), '0);

        report();
    end
endmodule